// File: doc/BRIEF.md
# Two-Channel CAN Repeater Core with Echo Suppression

This block joins two CAN transceiver channels into one logical bus segment. Any dominant level that channel A receives is driven onto channel B's transmit line, and the reverse. Neither side has priority. All lines are active-low: a 0 means dominant and a 1 means recessive.

A plain cross-connection would lock up. The repeater's own dominant on a bus comes back through that bus's receiver, gets forwarded back to the first bus, and keeps both buses dominant for good. To prevent this, each channel keeps a release flag. The flag drops in the same cycle that the channel's own transmit line goes dominant. While it is low, that channel's received level is not forwarded. After the transmit line returns recessive, the flag stays low for `HOLD_CYCLES` more cycles. This hold must be longer than the transceiver transmit delay plus the receive delay, with margin.

Receive inputs pass through a synchronizer, and transmit outputs come from registers. The forwarding path therefore has a fixed latency of `SYNC_STAGES + 1` cycles.

Top module: `can_repeater_core`

## Requirements
- R1: While reset is low, and in the first cycle after it, both transmit outputs are 1 (recessive), both release flags are high, and both hold counters are zero, whatever the receive inputs do.
- R2: A 0 (dominant) on one channel's receive input appears as a 0 on the other channel's transmit output exactly SYNC_STAGES+1 (default 3) clock edges later. The mapping is the same in both directions.
- R3: A forwarded dominant lasts exactly as many cycles as the received dominant that caused it, including a single-cycle pulse.
- R4: A channel's release flag is low in every cycle in which that channel's own transmit output is 0.
- R5: After a channel's transmit output returns to 1, its release flag stays low for exactly HOLD_CYCLES cycles and then goes high.
- R6: While a channel's release flag is low, the value forwarded from that channel's receive input is forced to 1, one edge later on the other channel's transmit output.
- R7: After a single external dominant pulse on either bus ends, the repeater's echo never reaches its origin channel's transmit output, and both buses return to recessive.
- R8: When external dominants overlap on both buses, the bus whose driver stops first goes recessive. Its transmit output goes dominant again HOLD_CYCLES+SYNC_STAGES+2 cycles after its receive input returned to 1, as long as the other receive input is still 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_a_n | input | 1 | Channel A receive level, 0 = dominant, asynchronous |
| rx_b_n | input | 1 | Channel B receive level, 0 = dominant, asynchronous |
| tx_a_n | output | 1 | Channel A transmit request, 0 = dominant |
| tx_b_n | output | 1 | Channel B transmit request, 0 = dominant |

## Verification
The bench drives its inputs at the falling edge. A receive change made there reaches the synchronizer at the next rising edge. The opposite transmit output then reflects it three rising edges later, and the bench reads it at the following falling edge. Every latency check is counted in those falling-edge steps from the step that drove the stimulus.

The bench wraps the block in a bus model. Each bus is a wired-AND of an external driver and the block's transmit line, delayed by three steps. Each receiver sees its bus three steps late. From these fixed delays, the bench predicts when the overlap gap opens and closes, to the exact step, and when the bus returns to recessive after a single pulse.

The release-flag timing is not visible at the ports, so it is checked cycle by cycle against a counter in the bound checker.

// File: rtl/crep_pkg.sv
// Shared constants and helpers for the two-channel repeater core.
// Assumes exactly two channels; channel 0 is A, channel 1 is B.
package crep_pkg;
    localparam int unsigned NUM_CH    = 2;
    localparam logic        RECESSIVE = 1'b1;
    localparam logic        DOMINANT  = 1'b0;

    // Index of the channel that a given channel forwards to and from.
    function automatic int unsigned peer_of(input int unsigned ch);
        return NUM_CH - 1 - ch;
    endfunction
endpackage

// File: rtl/crep_sync.sv
// Multi-flop synchronizer for one asynchronous active-low receive level.
// Resets to recessive so no spurious dominant appears after reset.
// Assumes STAGES >= 2.
module crep_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    import crep_pkg::*;

    logic [STAGES-1:0] shreg;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= {STAGES{RECESSIVE}};
        else        shreg <= {shreg[STAGES-2:0], d_i};
    end

    assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/crep_release.sv
// Echo-suppression timer for one channel.
// The release flag drops at once while the channel's own transmit output is dominant.
// It rises HOLD_CYCLES cycles after the transmit output goes recessive again.
// Assumes HOLD_CYCLES >= 1 and larger than the loop delay of the transceiver.
module crep_release #(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_n_i,
    output logic release_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] hold_cnt;

    // Reload while transmitting dominant, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_cnt <= '0;
        else if (!tx_n_i)            hold_cnt <= CW'(HOLD_CYCLES);
        else if (hold_cnt != '0)     hold_cnt <= hold_cnt - CW'(1);
    end

    // Released only when idle and the hold window has expired.
    always_comb begin
        release_o = tx_n_i && (hold_cnt == '0);
    end
endmodule

// File: rtl/can_repeater_core.sv
// Symmetric two-channel repeater core with per-channel echo suppression.
// Each channel's synchronized receive level is forwarded to the peer's
// registered transmit output. The forwarding is gated by the source
// channel's release flag, so the repeater never re-forwards its own echo.
// Assumes asynchronous receive inputs and a synchronous active-low reset.
module can_repeater_core #(
    parameter int unsigned HOLD_CYCLES = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_a_n,
    input  logic rx_b_n,
    output logic tx_a_n,
    output logic tx_b_n
);
    import crep_pkg::*;

    logic [NUM_CH-1:0] rx_raw;
    logic [NUM_CH-1:0] rx_sync;
    logic [NUM_CH-1:0] rel;
    logic [NUM_CH-1:0] fwd_next;
    logic [NUM_CH-1:0] tx_q;

    assign rx_raw = {rx_b_n, rx_a_n};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int unsigned PEER = peer_of(c);

            crep_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (rx_raw[c]),
                .q_o   (rx_sync[c])
            );

            crep_release #(.HOLD_CYCLES(HOLD_CYCLES)) u_rel (
                .clk       (clk),
                .rst_n     (rst_n),
                .tx_n_i    (tx_q[c]),
                .release_o (rel[c])
            );

            // Take the peer's level only while the peer is released.
            assign fwd_next[c] = rel[PEER] ? rx_sync[PEER] : RECESSIVE;
        end
    endgenerate

    // Register both transmit requests.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= {NUM_CH{RECESSIVE}};
        else        tx_q <= fwd_next;
    end

    assign tx_a_n = tx_q[0];
    assign tx_b_n = tx_q[1];
endmodule

// File: rtl/crep_chk.sv
// Protocol checker for can_repeater_core, attached with bind.
// It tracks each channel's hold window with its own counter.
// It then compares the release flags and the transmit outputs against that window.
module crep_chk #(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_a_n,
    input logic       tx_b_n,
    input logic [1:0] rel
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    logic [1:0] tx_n;
    assign tx_n = {tx_b_n, tx_a_n};

    // R1: reset forces both outputs recessive on the next edge.
    p_reset_recessive_r1: assert property (@(posedge clk)
        !rst_n |=> (tx_a_n && tx_b_n));

    generate
        for (genvar c = 0; c < 2; c++) begin : g_chk
            localparam int unsigned PEER = 1 - c;
            logic [CW-1:0] since_tx;

            // Count cycles since this channel's output was last dominant.
            always_ff @(posedge clk) begin
                if (!rst_n)                           since_tx <= CW'(HOLD_CYCLES);
                else if (!tx_n[c])                    since_tx <= '0;
                else if (since_tx < CW'(HOLD_CYCLES)) since_tx <= since_tx + CW'(1);
            end

            // R4: own dominant output keeps the flag low.
            p_release_on_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !tx_n[c] |-> !rel[c]);

            // R5: the flag stays low for the whole hold window.
            p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_n[c] && since_tx < CW'(HOLD_CYCLES)) |-> !rel[c]);

            // R5: the flag rises once the window is over.
            p_release_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_n[c] && since_tx == CW'(HOLD_CYCLES)) |-> rel[c]);

            // R6: a suppressed channel forwards recessive to its peer.
            p_block_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !rel[c] |=> tx_n[PEER]);
        end
    endgenerate
endmodule

bind can_repeater_core crep_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_a_n (tx_a_n),
    .tx_b_n (tx_b_n),
    .rel    (rel)
);

// File: tb/can_repeater_core_test.sv
// Self-checking bench: two wired-AND buses with fixed delays around the core.
module can_repeater_core_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HOLD = 16;
    localparam int  TD   = 3;   // transmit delay of the bus model, in steps
    localparam int  RD   = 3;   // receive delay of the bus model, in steps
    localparam int  LAT  = 3;   // sync stages + output register

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_a_n = 1'b1;
    logic rx_b_n = 1'b1;
    logic tx_a_n;
    logic tx_b_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_repeater_core #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .rx_a_n(rx_a_n), .rx_b_n(rx_b_n),
        .tx_a_n(tx_a_n), .tx_b_n(tx_b_n)
    );

    int checks = 0;
    int fails = 0;
    int step_no = 0;
    logic ext_a = 1'b1, ext_b = 1'b1, bus_a = 1'b1, bus_b = 1'b1, ta = 1'b1, tb = 1'b1;
    logic [TD-1:0] txa_line = '1, txb_line = '1;
    logic [RD-1:0] rxa_line = '1, rxb_line = '1;

    function automatic int exp_first_low();
        return RD + LAT;
    endfunction

    function automatic int exp_rx_to_tx_gap();
        return HOLD + LAT + 1;
    endfunction

    function automatic int exp_bus_gap();
        return RD + LAT + HOLD + 1 + TD;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One model step at the falling edge: sample outputs, update buses, drive receivers.
    task automatic step();
        @(negedge clk);
        step_no++;
        ta = tx_a_n;
        tb = tx_b_n;
        bus_a = ext_a & txa_line[TD-1];
        bus_b = ext_b & txb_line[TD-1];
        txa_line = {txa_line[TD-2:0], ta};
        txb_line = {txb_line[TD-2:0], tb};
        rx_a_n = rxa_line[RD-1];
        rx_b_n = rxb_line[RD-1];
        rxa_line = {rxa_line[RD-2:0], bus_a};
        rxb_line = {rxb_line[RD-2:0], bus_b};
    endtask

    // Single external pulse on one bus; measure both transmit outputs.
    task automatic one_way(input bit on_b, input int len);
        int start, first, far_cnt, near_cnt;
        logic far_v, near_v;
        start = step_no + 1;
        first = -1;
        far_cnt = 0;
        near_cnt = 0;
        if (on_b) ext_b = 1'b0; else ext_a = 1'b0;
        for (int i = 0; i < len + 70; i++) begin
            if (i == len) begin ext_a = 1'b1; ext_b = 1'b1; end
            step();
            far_v  = on_b ? ta : tb;
            near_v = on_b ? tb : ta;
            if (!far_v) begin
                if (first < 0) first = step_no - start;
                far_cnt++;
            end
            if (!near_v) near_cnt++;
        end
        chk(first == exp_first_low(), "R2 forward latency", first, exp_first_low());
        chk(far_cnt == len, "R3 forwarded length", far_cnt, len);
        chk(near_cnt == 0, "R7/R6 echo suppressed", near_cnt, 0);
        chk(ta && tb && bus_a && bus_b, "R7 no lockup", {ta, tb, bus_a, bus_b}, 15);
    endtask

    // Overlapping pulses: B starts first and ends first.
    task automatic overlap();
        int s0, rise_b, fall2_b, bus_a_runs, rxb_high, txb_low2;
        logic prev_b, prev_a, prev_rxb, prev_tb;
        s0 = step_no + 1;
        rise_b = -1; fall2_b = -1; bus_a_runs = 0; rxb_high = -1; txb_low2 = -1;
        prev_b = 1'b1; prev_a = 1'b1; prev_rxb = 1'b1; prev_tb = 1'b1;
        for (int i = 0; i < 200; i++) begin
            ext_b = !(i < 80);
            ext_a = !(i >= 40 && i < 120);
            step();
            if (bus_b && !prev_b && rise_b < 0) rise_b = step_no;
            if (!bus_b && prev_b && rise_b >= 0 && fall2_b < 0) fall2_b = step_no;
            if (!bus_a && prev_a) bus_a_runs++;
            if (rx_b_n && !prev_rxb && rxb_high < 0) rxb_high = step_no;
            if (!tb && prev_tb && txb_low2 < 0) txb_low2 = step_no;
            prev_b = bus_b; prev_a = bus_a; prev_rxb = rx_b_n; prev_tb = tb;
        end
        chk(rise_b == s0 + 80, "R8 gap opens", rise_b - s0, 80);
        chk(fall2_b - rise_b == exp_bus_gap(), "R8 bus gap length", fall2_b - rise_b, exp_bus_gap());
        chk(txb_low2 - rxb_high == exp_rx_to_tx_gap(), "R8 R5 rx-to-tx hold", txb_low2 - rxb_high,
            exp_rx_to_tx_gap());
        chk(bus_a_runs == 1, "R8 other bus continuous", bus_a_runs, 1);
        chk(ta && tb && bus_a && bus_b, "R7 no lockup after overlap", {ta, tb, bus_a, bus_b}, 15);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: receive dominant during reset must not reach the outputs.
        rx_a_n = 1'b0;
        rx_b_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(tx_a_n && tx_b_n, "R1 reset recessive", {tx_a_n, tx_b_n}, 3);
        rx_a_n = 1'b1;
        rx_b_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_a_n && tx_b_n, "R1 after reset", {tx_a_n, tx_b_n}, 3);

        one_way(1'b1, 10);   // R2 B to A
        one_way(1'b0, 10);   // R2 A to B, symmetry
        one_way(1'b0, 1);    // R3 single-cycle pulse
        one_way(1'b1, 60);   // R7 long pulse, far longer than hold
        overlap();           // R8
        for (int n = 0; n < 12; n++) begin
            one_way(1'($urandom % 2), 1 + int'($urandom % 40));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule